// File: doc/BRIEF.md
# Hysteretic Loss-of-Signal Detector

This block watches a serial receive bit stream, one bit for each cycle in which the bit-enable input is high, and decides whether the line has lost its signal. The signal is declared lost after an unbroken run of spaces (zeros) of a set length. Once the signal is lost, the loss is withdrawn only when the recent stream carries enough marks (ones). That density is measured over a sliding window of the most recent accepted bits.

Entry and exit use different criteria, so the loss indication has hysteresis. A line that is mostly quiet does not flap the output. Sparse marks are not enough to bring the line back, but a single mark is enough to stop the line from being declared lost.

The block drives a level output that holds the loss state. It also drives a one-cycle change pulse, which fires on the same clock edge that the level changes, in either direction. Line decoding and the register interface belong to the blocks around this one. With the default parameters the run threshold is 180 zeros, the window is 180 bits and the mark threshold is 60.

Top module: `los_hyst_det`

## Requirements
- R1: Synchronous active-high reset forces `los` and `los_chg` low, clears the zero-run count and empties the mark window. Marks accepted before the reset do not count toward a later exit.
- R2: While `los` is low, the edge that accepts the RUN_LEN-th consecutive zero sets `los`. With RUN_LEN-1 consecutive zeros, `los` stays low.
- R3: An accepted mark restarts the zero run, so zeros accepted before that mark never count toward entry.
- R4: While `los` is high, on each accepted bit the block counts the marks among the last WIN_LEN accepted bits, including the current bit. When that count is at least MARK_MIN, `los` clears on that edge. MARK_MIN-1 marks in the window leave it set.
- R5: A mark that has moved more than WIN_LEN accepted bits into the past no longer counts toward exit.
- R6: `los_chg` is high for exactly the one cycle after each edge at which `los` changes, in either direction, and is low otherwise.
- R7: On a cycle with `bit_en` low, `bit_in` is ignored. The zero run, the mark window and `los` keep their values, and `los_chg` is low.
- R8: While `los` is high, further zeros keep it high and produce no new change pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Qualifies `bit_in` as a new line bit |
| bit_in | input | 1 | Received line bit, 1 = mark, 0 = space |
| los | output | 1 | Loss-of-signal level, registered |
| los_chg | output | 1 | One-cycle pulse when `los` changes, registered |

## Verification
A corrupt zero-run count shows up as a `los` rise that is too early or too late, on the edge of the RUN_LEN-th zero. A missed restart on a mark only shows up once the following zeros reach the threshold. A wrong window count or a stale ring entry shows up only while `los` is high, as an exit that comes early or late. That fault can stay hidden until as many as WIN_LEN accepted bits later, when a stale mark should have left the window. The bench therefore compares both outputs after every cycle against a model built on the bit history. It uses a configuration whose window is longer than the run threshold, so that marks left in the window across an entry, and marks left from before a reset, both show up at the outputs.

// File: rtl/los_pkg.sv
package los_pkg;
  typedef enum logic {
    LINK_OK   = 1'b0,
    LINK_LOST = 1'b1
  } link_state_t;
endpackage

// File: rtl/zero_run_ctr.sv
module zero_run_ctr #(
  parameter int RUN_LEN = 180
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic bit_in,
  output logic run_hit,
  output logic run_full
);
  localparam int RW = $clog2(RUN_LEN + 1);

  logic [RW-1:0] run_cnt;

  // the zero being accepted this cycle completes (or extends) a full run
  assign run_hit  = bit_en && !bit_in && (run_cnt >= RW'(RUN_LEN - 1));
  assign run_full = (run_cnt == RW'(RUN_LEN));

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
    end else if (bit_en) begin
      if (bit_in)
        run_cnt <= '0;
      else if (run_cnt != RW'(RUN_LEN))
        run_cnt <= run_cnt + 1'b1;
    end
  end

  AST_RUN_SATURATES: assert property (@(posedge clk) disable iff (rst)
    run_cnt <= RW'(RUN_LEN)); // R2
  AST_MARK_RESTARTS_RUN: assert property (@(posedge clk) disable iff (rst)
    (bit_en && bit_in) |=> (run_cnt == '0)); // R3
endmodule

// File: rtl/mark_window.sv
module mark_window #(
  parameter int WIN_LEN  = 180,
  parameter int MARK_MIN = 60
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic bit_in,
  output logic dense,
  output logic [$clog2(WIN_LEN+1)-1:0] mark_cnt
);
  localparam int CW = $clog2(WIN_LEN + 1);
  localparam int PW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;

  logic          ring [WIN_LEN];
  logic [PW-1:0] wr_ptr;
  logic          filled;
  logic          old_bit;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nx;

  // slots not yet written since reset count as spaces
  assign old_bit = filled ? ring[wr_ptr] : 1'b0;
  assign cnt_nx  = cnt_q + CW'(bit_in) - CW'(old_bit);
  assign dense   = bit_en && (cnt_nx >= CW'(MARK_MIN));
  assign mark_cnt = cnt_q;

  // storage without reset so that it can map onto RAM
  always_ff @(posedge clk) begin
    if (bit_en)
      ring[wr_ptr] <= bit_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      filled <= 1'b0;
      cnt_q  <= '0;
    end else if (bit_en) begin
      cnt_q <= cnt_nx;
      if (wr_ptr == PW'(WIN_LEN - 1)) begin
        wr_ptr <= '0;
        filled <= 1'b1;
      end else begin
        wr_ptr <= wr_ptr + 1'b1;
      end
    end
  end

  AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(WIN_LEN)); // R5
  AST_WINDOW_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(cnt_q)); // R7
endmodule

// File: rtl/los_hyst_det.sv
module los_hyst_det #(
  parameter int RUN_LEN  = 180,
  parameter int WIN_LEN  = 180,
  parameter int MARK_MIN = 60
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic bit_in,
  output logic los,
  output logic los_chg
);
  import los_pkg::*;

  localparam int CW = $clog2(WIN_LEN + 1);

  logic          run_hit;
  logic          run_full;
  logic          dense;
  logic [CW-1:0] mark_cnt;
  link_state_t   st_q;
  link_state_t   st_d;

  zero_run_ctr #(.RUN_LEN(RUN_LEN)) u_run (
    .clk      (clk),
    .rst      (rst),
    .bit_en   (bit_en),
    .bit_in   (bit_in),
    .run_hit  (run_hit),
    .run_full (run_full)
  );

  mark_window #(.WIN_LEN(WIN_LEN), .MARK_MIN(MARK_MIN)) u_win (
    .clk      (clk),
    .rst      (rst),
    .bit_en   (bit_en),
    .bit_in   (bit_in),
    .dense    (dense),
    .mark_cnt (mark_cnt)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      LINK_OK:   if (run_hit) st_d = LINK_LOST;
      LINK_LOST: if (dense)   st_d = LINK_OK;
      default:   st_d = LINK_OK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= LINK_OK;
      los_chg <= 1'b0;
    end else begin
      st_q    <= st_d;
      los_chg <= (st_d != st_q);
    end
  end

  assign los = (st_q == LINK_LOST);

  AST_ENTRY_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
    $rose(los) |-> run_full); // R2
  AST_EXIT_WITH_MARKS: assert property (@(posedge clk) disable iff (rst)
    $fell(los) |-> (mark_cnt >= CW'(MARK_MIN))); // R4
  AST_PULSE_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    los_chg |-> (los != $past(los))); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> ($stable(los) && !los_chg)); // R7
endmodule

// File: tb/test_los_hyst_det.sv
`timescale 1ns/1ps
module test_los_hyst_det;
  localparam int RUN = 12;
  localparam int WIN = 16;
  localparam int MIN = 5;
  localparam int HMAX = 8192;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0;
  logic bit_in = 1'b0;
  logic los;
  logic los_chg;

  int checks = 0;
  int fails = 0;

  bit hist [HMAX];
  int n = 0;
  logic exp_los = 1'b0;
  logic exp_chg = 1'b0;

  always #2.5 clk = ~clk;

  los_hyst_det #(.RUN_LEN(RUN), .WIN_LEN(WIN), .MARK_MIN(MIN)) i_los_hyst_det (
    .clk     (clk),
    .rst     (rst),
    .bit_en  (bit_en),
    .bit_in  (bit_in),
    .los     (los),
    .los_chg (los_chg)
  );

  task automatic check(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b (bit %0d)", req, what, act, exp, n);
    end
  endtask

  function automatic int zero_run();
    int r = 0;
    for (int i = n - 1; i >= 0 && r < RUN; i--) begin
      if (hist[i]) break;
      r++;
    end
    return r;
  endfunction

  function automatic int win_marks();
    int c = 0;
    for (int i = (n > WIN ? n - WIN : 0); i < n; i++) c += int'(hist[i]);
    return c;
  endfunction

  task automatic step(input logic d, input logic en, input string req);
    @(negedge clk);
    bit_in = d;
    bit_en = en;
    @(posedge clk);
    #1;
    exp_chg = 1'b0;
    if (en) begin
      if (n < HMAX) begin
        hist[n] = d;
        n++;
      end
      if (!exp_los && zero_run() >= RUN) begin
        exp_los = 1'b1;
        exp_chg = 1'b1;
      end else if (exp_los && win_marks() >= MIN) begin
        exp_los = 1'b0;
        exp_chg = 1'b1;
      end
    end
    check(los, exp_los, req, "los");
    check(los_chg, exp_chg, req, "los_chg");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    bit_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    n = 0;
    exp_los = 1'b0;
    exp_chg = 1'b0;
    check(los, 1'b0, "R1", "los after reset");
    check(los_chg, 1'b0, "R1", "los_chg after reset");
  endtask

  task automatic zeros(input int k, input string req);
    for (int i = 0; i < k; i++) step(1'b0, 1'b1, req);
  endtask

  task automatic marks(input int k, input string req);
    for (int i = 0; i < k; i++) step(1'b1, 1'b1, req);
  endtask

  initial begin
    #(5.0 * 190000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();

    // R2: one short of the threshold, then exactly at it
    zeros(RUN - 1, "R2");
    check(los, 1'b0, "R2", "no los at RUN-1 zeros");
    // R3: a mark restarts the run
    marks(1, "R3");
    zeros(RUN - 1, "R3");
    check(los, 1'b0, "R3", "run restarted by mark");
    zeros(1, "R2");
    check(los, 1'b1, "R2", "los at RUN zeros");
    check(los_chg, 1'b1, "R6", "entry pulse");
    // R8: more zeros hold los without a pulse
    zeros(20, "R8");
    check(los_chg, 1'b0, "R8", "no pulse while lost");
    // R4: MIN-1 marks do not clear, the MIN-th does
    marks(MIN - 1, "R4");
    check(los, 1'b1, "R4", "MIN-1 marks keep los");
    marks(1, "R4");
    check(los, 1'b0, "R4", "MIN marks clear los");
    check(los_chg, 1'b1, "R6", "exit pulse");
    step(1'b0, 1'b1, "R6");
    check(los_chg, 1'b0, "R6", "pulse one cycle");

    // R5: marks that slid out of the window do not count
    marks(MIN - 1, "R5");
    zeros(WIN + 2, "R5");
    marks(MIN - 1, "R5");
    check(los, 1'b1, "R5", "stale marks expired");
    marks(1, "R5");
    check(los, 1'b0, "R5", "fresh marks clear");

    // R7: bit_en low ignores data
    zeros(RUN - 1, "R7");
    for (int i = 0; i < 30; i++) step(1'b0, 1'b0, "R7");
    check(los, 1'b0, "R7", "held zeros not counted");
    zeros(1, "R7");
    check(los, 1'b1, "R7", "run resumed after hold");
    for (int i = 0; i < 30; i++) step(1'b1, 1'b0, "R7");
    check(los, 1'b1, "R7", "held marks not counted");

    // R1: marks before reset do not survive it
    do_reset();
    marks(MIN - 1, "R1");
    do_reset();
    zeros(RUN, "R1");
    check(los, 1'b1, "R1", "entry after reset");
    marks(1, "R1");
    check(los, 1'b1, "R1", "pre-reset marks cleared");

    // sweep over mark densities and enable rates
    foreach (hist[i]) hist[i] = 1'b0;
    do_reset();
    for (int p = 0; p < 8; p++) begin
      int pm;
      pm = (p == 0) ? 2 : (p == 1) ? 5 : (p == 2) ? 10 : (p == 3) ? 20 :
           (p == 4) ? 35 : (p == 5) ? 50 : (p == 6) ? 8 : 3;
      for (int i = 0; i < 1000; i++) begin
        step(($urandom_range(99) < pm) ? 1'b1 : 1'b0,
             ($urandom_range(99) < 75) ? 1'b1 : 1'b0, "R2/R4/R5/R6/R7");
      end
      if (p == 3) do_reset();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule